// File: doc/BRIEF.md
# Dual-Form Serial CRC-32 Engine

This block computes a 32-bit cyclic redundancy check one bit per clock. It can run its register in either of two forms. In the multiply-divide form the incoming bit is XORed with the register's top bit, and that sum drives the polynomial feedback. The result is the message times x^32, reduced modulo the generator. In the divide-only form the incoming bit is shifted into the bottom of the register, and feedback is taken from the top bit alone. That gives a plain remainder, so the caller appends 32 zero bits to the message to get the same augmented result.

A start pulse presets the register to all zeros or all ones and latches the form for the frame. The transmit side reads the complemented register once the message, or the augmented message, has been absorbed. The receive side feeds the frame with its complemented check field, plus 32 zero bits in divide-only form. A match flag then shows whether the register holds the fixed residue constant.

Bits are taken most significant first. The first bit fed is the highest-degree coefficient, and the check field is sent starting from register bit 31. Bit reflection and byte ordering belong to the surrounding framing logic.

Top module: `crc32_dual_serial`

## Requirements
- R1: While `rst_n` is low the register clears to zero and the latched form returns to multiply-divide. After reset, `crc_reg_o` reads 0, `crc_tx_o` reads all ones, and `residue_ok_o` is 0.
- R2: A cycle with `start_i` high loads the register with all ones when `preload_ones_i` is 1 and with zero when it is 0. It also latches `form_sel_i`, where 0 means multiply-divide and 1 means divide-only. Start takes precedence over `bit_en_i` in the same cycle.
- R3: A cycle with both `start_i` and `bit_en_i` low leaves the register unchanged, whatever `din_i` holds.
- R4: In multiply-divide form, after n valid bits M from preset I, the register equals (I·x^n + M·x^32) mod G. G is x^32 plus the `POLY` parameter.
- R5: In divide-only form, after n valid bits M from preset I, the register equals (I·x^n + M) mod G.
- R6: In multiply-divide form, an all-ones preset yields the same register as a zero preset with the first 32 message bits inverted.
- R7: In divide-only form, on an augmented message, an all-ones preset equals the multiply-divide result from a zero preset with the first 32 bits XORed with the residue constant K. It differs from the divide-only result from a zero preset with the first 32 bits inverted.
- R8: `crc_tx_o` is the bitwise complement of the register and changes on the same clock edge as the register.
- R9: `residue_ok_o` is 1 exactly when the register equals K = (all-ones · x^32) mod G. In either form, a frame carrying its complemented check field from an all-ones preset produces this value, and a single flipped bit does not.
- R10: Changes of `form_sel_i` between start pulses have no effect on the result.
- R11: With only zero input bits, the register after n bits equals the preset times x^n mod G, in both forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Preset register and latch form |
| bit_en_i | input | 1 | Current `din_i` is a valid message bit |
| din_i | input | 1 | Serial data bit |
| form_sel_i | input | 1 | 0 = multiply-divide, 1 = divide-only |
| preload_ones_i | input | 1 | Preset value: 1 = all ones, 0 = zero |
| crc_reg_o | output | 32 | Register contents |
| crc_tx_o | output | 32 | Complemented register for transmission |
| residue_ok_o | output | 1 | Register equals the residue constant |

## Verification
The bench builds the block with its default polynomial 0x1EDC6F41. Because the bench derives the residue constant from that polynomial with its own long division, the match flag is checked against a value the RTL never hands it. Random message lengths from 33 to 160 bits reach the cases where the preset is shifted far past the register width, where the x^n and x^(n+32) terms that separate the two forms diverge. Idle cycles with toggling data and a form select that changes mid-frame are interleaved at random.

// File: rtl/crc_dual_pkg.sv
package crc_dual_pkg;
  localparam int CRC_W = 32;
  typedef logic [CRC_W-1:0] crc_t;
  typedef enum logic {FORM_MULDIV = 1'b0, FORM_DIVONLY = 1'b1} crc_form_e;

  // Feedback = message bit XOR register MSB; message enters via taps.
  function automatic crc_t step_muldiv(crc_t r, logic d, crc_t poly);
    logic fb;
    fb = d ^ r[CRC_W-1];
    return (r << 1) ^ (fb ? poly : '0);
  endfunction

  // Message enters at the LSB; feedback from MSB only.
  function automatic crc_t step_divonly(crc_t r, logic d, crc_t poly);
    return {r[CRC_W-2:0], d} ^ (r[CRC_W-1] ? poly : '0);
  endfunction

  // All-ones times x^W, reduced: the receiver residue constant.
  function automatic crc_t residue_of(crc_t poly);
    crc_t r;
    r = '1;
    for (int i = 0; i < CRC_W; i++) r = step_muldiv(r, 1'b0, poly);
    return r;
  endfunction
endpackage

// File: rtl/crc_md_stage.sv
module crc_md_stage
  import crc_dual_pkg::*;
#(
  parameter crc_t POLY = 32'h1EDC6F41
) (
  input  crc_t state_i,
  input  logic din_i,
  output crc_t next_o,
  output logic fb_o
);
  assign fb_o   = din_i ^ state_i[CRC_W-1];
  assign next_o = step_muldiv(state_i, din_i, POLY);
endmodule

// File: rtl/crc_do_stage.sv
module crc_do_stage
  import crc_dual_pkg::*;
#(
  parameter crc_t POLY = 32'h1EDC6F41
) (
  input  crc_t state_i,
  input  logic din_i,
  output crc_t next_o,
  output logic fb_o
);
  assign fb_o   = state_i[CRC_W-1];
  assign next_o = step_divonly(state_i, din_i, POLY);
endmodule

// File: rtl/crc_residue_cmp.sv
module crc_residue_cmp
  import crc_dual_pkg::*;
#(
  parameter crc_t POLY = 32'h1EDC6F41
) (
  input  crc_t state_i,
  output logic match_o
);
  localparam crc_t RESIDUE = residue_of(POLY);
  assign match_o = (state_i == RESIDUE);
endmodule

// File: rtl/crc32_dual_serial.sv
module crc32_dual_serial
  import crc_dual_pkg::*;
#(
  parameter crc_t POLY = 32'h1EDC6F41
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        bit_en_i,
  input  logic        din_i,
  input  logic        form_sel_i,
  input  logic        preload_ones_i,
  output logic [31:0] crc_reg_o,
  output logic [31:0] crc_tx_o,
  output logic        residue_ok_o
);
  crc_t      crc_q, crc_d, md_next, do_next, preset_val;
  crc_form_e form_q;
  logic      md_fb, do_fb;
  logic      load_ev, step_ev, idle_ev;

  // Named events for assertions
  assign load_ev    = start_i;
  assign step_ev    = bit_en_i && !start_i;
  assign idle_ev    = !bit_en_i && !start_i;
  assign preset_val = preload_ones_i ? '1 : '0;

  crc_md_stage #(.POLY(POLY)) u_md (
    .state_i(crc_q), .din_i(din_i), .next_o(md_next), .fb_o(md_fb));
  crc_do_stage #(.POLY(POLY)) u_do (
    .state_i(crc_q), .din_i(din_i), .next_o(do_next), .fb_o(do_fb));

  always_comb begin
    crc_d = crc_q;
    if (load_ev)      crc_d = preset_val;
    else if (step_ev) crc_d = (form_q == FORM_DIVONLY) ? do_next : md_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      form_q <= FORM_MULDIV;
    end else begin
      crc_q <= crc_d;
      if (load_ev) form_q <= crc_form_e'(form_sel_i);
    end
  end

  crc_residue_cmp #(.POLY(POLY)) u_cmp (.state_i(crc_q), .match_o(residue_ok_o));

  assign crc_reg_o = crc_q;
  assign crc_tx_o  = ~crc_q;

  // R2: preset lands one edge after start
  a_r2_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (crc_q == ($past(preload_ones_i) ? '1 : '0)));
  // R3: idle cycles hold the register
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ev |=> $stable(crc_q));
  // R10: form only changes on a start
  a_r10_form_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(form_q));
  // R4: zero feedback in multiply-divide form is a pure shift
  a_r4_md_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && form_q == FORM_MULDIV && !md_fb) |=> (crc_q == ($past(crc_q) << 1)));
  // R5: zero feedback in divide-only form shifts the bit in at the LSB
  a_r5_do_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && form_q == FORM_DIVONLY && !do_fb) |=>
      (crc_q == {$past(crc_q[CRC_W-2:0]), $past(din_i)}));
endmodule

// File: tb/sim_crc32_dual_serial.sv
module sim_crc32_dual_serial;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] G = 32'h1EDC6F41;

  logic clk = 0, rst_n = 0;
  logic start = 0, bit_en = 0, din = 0, form_sel = 0, preload = 0;
  logic [31:0] crc_reg, crc_tx;
  logic residue_ok;
  int total = 0, bad = 0;
  logic dv [0:511];
  logic seq [0:511];
  logic [31:0] kres;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc32_dual_serial u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bit_en_i(bit_en), .din_i(din),
    .form_sel_i(form_sel), .preload_ones_i(preload),
    .crc_reg_o(crc_reg), .crc_tx_o(crc_tx), .residue_ok_o(residue_ok));

  // Plain long division of dv[0..len-1] (first = highest degree) by x^32+G
  function automatic logic [31:0] divrem(int len);
    logic [32:0] rem = '0;
    for (int i = 0; i < len; i++) begin
      rem = {rem[31:0], dv[i]};
      if (rem[32]) rem = rem ^ {1'b1, G};
    end
    return rem[31:0];
  endfunction

  // (I*x^n + M*x^32) mod G, by linearity
  function automatic logic [31:0] exp_md(logic [31:0] pre, int n);
    logic [31:0] a, b;
    for (int i = 0; i < 32; i++) dv[i] = pre[31-i];
    for (int i = 0; i < n; i++) dv[32+i] = 1'b0;
    a = divrem(32 + n);
    for (int i = 0; i < n; i++) dv[i] = seq[i];
    for (int i = 0; i < 32; i++) dv[n+i] = 1'b0;
    b = divrem(n + 32);
    return a ^ b;
  endfunction

  // (I*x^n + M) mod G
  function automatic logic [31:0] exp_do(logic [31:0] pre, int n);
    for (int i = 0; i < 32; i++) dv[i] = pre[31-i];
    for (int i = 0; i < n; i++) dv[32+i] = seq[i];
    return divrem(32 + n);
  endfunction

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  task automatic play(input logic pre, input logic form, input int len);
    @(negedge clk); start = 1; preload = pre; form_sel = form; bit_en = 0;
    @(negedge clk); start = 0;
    for (int i = 0; i < len; i++) begin
      if ($urandom % 4 == 0) begin
        bit_en = 0; din = 1'($urandom); form_sel = 1'($urandom);
        @(negedge clk);
      end
      bit_en = 1; din = seq[i]; form_sel = 1'($urandom);
      @(negedge clk);
    end
    bit_en = 0; din = 0;
  endtask

  task automatic rand_seq(input int len);
    for (int i = 0; i < len; i++) seq[i] = 1'($urandom);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] r_a, r_b, r_c, held;
    int n;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) dv[i] = 1'b1;
    for (int i = 0; i < 32; i++) dv[32+i] = 1'b0;
    kres = divrem(64);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk32("R1 reg", crc_reg, 32'h0);
    chk32("R1 tx", crc_tx, 32'hFFFFFFFF);
    chk32("R1 flag", {31'b0, residue_ok}, 32'h0);
    rst_n = 1;

    // R2 start loads preset, with priority over a bit in the same cycle
    @(negedge clk); start = 1; preload = 1; bit_en = 1; din = 1;
    @(negedge clk); start = 0; bit_en = 0;
    chk32("R2 ones", crc_reg, 32'hFFFFFFFF);
    @(negedge clk); start = 1; preload = 0; bit_en = 1; din = 1;
    @(negedge clk); start = 0; bit_en = 0;
    chk32("R2 zero", crc_reg, 32'h0);

    // R4 / R5 / R8 / R10 random frames in both forms and presets
    for (int t = 0; t < 24; t++) begin
      logic pre, form;
      n = 33 + ($urandom % 128);
      pre = 1'($urandom); form = 1'(t % 2);
      rand_seq(n);
      play(pre, form, n);
      r_a = form ? exp_do(pre ? 32'hFFFFFFFF : 32'h0, n) : exp_md(pre ? 32'hFFFFFFFF : 32'h0, n);
      chk32(form ? "R5 R10 divonly" : "R4 R10 muldiv", crc_reg, r_a);
      chk32("R8 tx", crc_tx, ~r_a);
    end

    // R3 idle cycles with toggling data
    held = crc_reg;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); din = ~din; form_sel = ~form_sel;
    end
    @(negedge clk);
    chk32("R3 idle", crc_reg, held);

    // R11 zero input, both forms
    n = 77;
    for (int i = 0; i < n; i++) seq[i] = 1'b0;
    for (int i = 0; i < 32; i++) dv[i] = 1'b1;
    for (int i = 0; i < n; i++) dv[32+i] = 1'b0;
    r_a = divrem(32 + n);
    play(1'b1, 1'b0, n); chk32("R11 muldiv", crc_reg, r_a);
    play(1'b1, 1'b1, n); chk32("R11 divonly", crc_reg, r_a);

    // R6 muldiv: ones preset == zero preset with inverted prefix
    n = 90; rand_seq(n);
    play(1'b1, 1'b0, n); r_a = crc_reg;
    for (int i = 0; i < 32; i++) seq[i] = ~seq[i];
    play(1'b0, 1'b0, n); r_b = crc_reg;
    chk32("R6 equal", r_b, r_a);

    // R7 divonly on augmented message
    n = 70; rand_seq(n);
    for (int i = 0; i < 32; i++) seq[n+i] = 1'b0;
    play(1'b1, 1'b1, n + 32); r_a = crc_reg;
    for (int i = 0; i < 32; i++) seq[i] = ~seq[i];
    play(1'b0, 1'b1, n + 32); r_c = crc_reg;
    for (int i = 0; i < 32; i++) seq[i] = ~seq[i] ^ kres[31-i];
    play(1'b0, 1'b0, n); r_b = crc_reg;
    chk32("R7 K-prefix equal", r_a, r_b);
    total++;
    if (r_a === r_c) begin
      bad++;
      $display("FAIL R7 inverted-prefix actual=%08h expected!=%08h", r_c, r_a);
    end

    // R9 residue, multiply-divide
    n = 64; rand_seq(n);
    play(1'b1, 1'b0, n); r_a = crc_tx;
    for (int i = 0; i < 32; i++) seq[n+i] = r_a[31-i];
    play(1'b1, 1'b0, n + 32);
    chk32("R9 md residue", crc_reg, kres);
    chk32("R9 md flag", {31'b0, residue_ok}, 32'h1);
    seq[5] = ~seq[5];
    play(1'b1, 1'b0, n + 32);
    chk32("R9 md corrupt flag", {31'b0, residue_ok}, 32'h0);

    // R9 residue, divide-only
    n = 48; rand_seq(n);
    for (int i = 0; i < 32; i++) seq[n+i] = 1'b0;
    play(1'b1, 1'b1, n + 32); r_a = crc_tx;
    for (int i = 0; i < 32; i++) seq[n+i] = r_a[31-i];
    for (int i = 0; i < 32; i++) seq[n+32+i] = 1'b0;
    play(1'b1, 1'b1, n + 64);
    chk32("R9 do residue", crc_reg, kres);
    chk32("R9 do flag", {31'b0, residue_ok}, 32'h1);
    seq[n+3] = ~seq[n+3];
    play(1'b1, 1'b1, n + 64);
    chk32("R9 do corrupt flag", {31'b0, residue_ok}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule